// File: doc/BRIEF.md
# Predictive Bit-Serial Neuron Processing Element

This block produces one output neuron of a dot-product layer from a stream of activation/weight pairs. It works through the stream twice on a single bit-serial multiply-accumulate datapath. The first pass is the prediction pass. It multiplies the upper nibble of each unsigned 8-bit activation by the full signed 8-bit weight and gives that product a weight of 16. When the pass ends, the block bounds what the lower nibbles could still add and decides whether the neuron can matter to the nonlinearity that follows.

In ReLU mode the neuron is dropped when even the most favourable lower nibbles cannot lift the sum above zero. In max-pool mode the block keeps a window floor: the largest guaranteed (pessimistic) value seen so far in the current pooling window. A neuron whose optimistic bound lies strictly under that floor is dropped. A dropped neuron finishes at once, with a zero result and a skipped flag. A kept neuron asks its source to replay the stream from the first pair. The block then adds the lower-nibble products to the partial sum it already holds, so the upper-nibble work is never repeated.

The controller is a state machine with these states:
- ST_IDLE: waits for a neuron start.
- ST_PRED_LOAD and ST_PRED_MAC: the prediction pass. LOAD accepts a pair; MAC spends four serial cycles on its upper nibble.
- ST_JUDGE: one decision cycle.
- ST_EXEC_LOAD and ST_EXEC_MAC: the same structure, used for the lower nibbles.
- ST_FINISH: one cycle that presents the result.

The transitions are:
- ST_IDLE goes to ST_PRED_LOAD on a start.
- A LOAD state goes to its MAC state when a pair is accepted.
- A MAC state goes back to its LOAD state after the fourth bit. After the last pair it goes instead to ST_JUDGE (prediction) or ST_FINISH (execution).
- ST_JUDGE goes to ST_FINISH on a skip, otherwise to ST_EXEC_LOAD.
- ST_FINISH goes to ST_IDLE.

Top module: `psn_neuron`

## Requirements
- R1: After reset, nrn_ready is 1 and pair_ready, exec_pass and done are 0.
- R2: The prediction pass accepts exactly N_PAIRS pairs. Its partial sum P is the sum of 16·act[7:4]·wgt, with the weight in two's complement.
- R3: A neuron that is not skipped returns P plus the sum of act[3:0]·wgt over the replayed stream. This equals the full sum of act·wgt, as a 24-bit two's-complement value.
- R4: With nrn_mode=0 (ReLU), the neuron is skipped exactly when P + 15·(sum of positive weights) ≤ 0.
- R5: With nrn_mode=1 (max-pool), the neuron is skipped exactly when the window holds a floor F and P + 15·(sum of positive weights) < F.
  - A kept neuron raises F to P + 15·(sum of negative weights) if that value is larger, or sets F if the window holds none.
  - A start with nrn_win_first=1 empties the window.
  - ReLU neurons leave the window untouched.
- R6: A skipped neuron raises done together with skipped=1 and result=0. It accepts no further pairs.
- R7: A kept neuron holds exec_pass high while it accepts exactly N_PAIRS more pairs, replayed from the first, and then raises done with skipped=0.
- R8: Every accepted pair is followed by exactly four cycles with pair_ready low. From the start handshake to done takes 5·N_PAIRS+1 cycles for a skipped neuron and 10·N_PAIRS+1 cycles for a kept one, when pairs are offered without gaps.
- R9: done is a single-cycle pulse. nrn_ready and pair_ready are never high together. nrn_ready drops in the cycle after an accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| nrn_start | input | 1 | Begin a neuron (taken while nrn_ready) |
| nrn_mode | input | 1 | 0 = ReLU judgement, 1 = max-pool judgement |
| nrn_win_first | input | 1 | Neuron opens a new pooling window |
| nrn_ready | output | 1 | Block idle, a start is accepted |
| pair_valid | input | 1 | Activation/weight pair offered |
| pair_act | input | 2·SLICE_W | Unsigned activation |
| pair_wgt | input | WGT_W | Signed weight |
| pair_ready | output | 1 | Pair accepted this cycle if valid |
| exec_pass | output | 1 | Execution pass running; source replays the stream |
| done | output | 1 | Result valid pulse |
| skipped | output | 1 | Neuron predicted ineffectual (with done) |
| result | output | ACC_W | Signed neuron sum, 0 when skipped |

## Verification
The checker watches the following on every cycle:
- The four-cycle pair_ready gap after each accepted pair.
- The single-cycle done pulse and the zero result that comes with a skip.
- That nrn_ready and pair_ready never overlap, and that nrn_ready drops after a start.
- That done never appears while exec_pass is high.

Only the bench scenarios can show the arithmetic. This covers the exact sums of kept neurons, the ReLU threshold at exactly zero, the strict comparison against the max-pool floor, and the window clear on nrn_win_first. The bench also counts the pairs consumed in each case and measures the start-to-done latency.

// File: rtl/psn_pkg.sv
package psn_pkg;

    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_PRED_LOAD = 3'd1,
        ST_PRED_MAC  = 3'd2,
        ST_JUDGE     = 3'd3,
        ST_EXEC_LOAD = 3'd4,
        ST_EXEC_MAC  = 3'd5,
        ST_FINISH    = 3'd6
    } psn_state_e;

    typedef enum logic {
        MODE_RELU    = 1'b0,
        MODE_MAXPOOL = 1'b1
    } psn_mode_e;

endpackage

// File: rtl/psn_serial_mac.sv
// Bit-serial multiply-accumulate: one activation bit per step, shifted weight added.
module psn_serial_mac #(
    parameter int SLICE_W = 4,
    parameter int WGT_W   = 8,
    parameter int ACC_W   = 24
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clr,
    input  logic                       load,
    input  logic [SLICE_W-1:0]         slice_in,
    input  logic signed [WGT_W-1:0]    wgt_in,
    input  logic                       step,
    input  logic                       hi_pass,
    input  logic [$clog2(SLICE_W)-1:0] bit_idx,
    output logic signed [ACC_W-1:0]    acc
);
    localparam int SH_W = $clog2(2 * SLICE_W) + 1;

    logic [SLICE_W-1:0]      slice_q;
    logic signed [WGT_W-1:0] wgt_q;
    logic signed [ACC_W-1:0] wgt_ext;
    logic signed [ACC_W-1:0] term;
    logic [SH_W-1:0]         shamt;

    always_comb begin
        wgt_ext = {{(ACC_W-WGT_W){wgt_q[WGT_W-1]}}, wgt_q};
        shamt   = SH_W'(bit_idx) + (hi_pass ? SH_W'(SLICE_W) : '0);
        term    = slice_q[bit_idx] ? (wgt_ext <<< shamt) : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slice_q <= '0;
            wgt_q   <= '0;
            acc     <= '0;
        end else begin
            if (clr) begin
                acc <= '0;
            end else if (step) begin
                acc <= acc + term;
            end
            if (load) begin
                slice_q <= slice_in;
                wgt_q   <= wgt_in;
            end
        end
    end
endmodule

// File: rtl/psn_judge.sv
// Effectualness judgement: low-nibble bounds and the max-pool window floor.
module psn_judge #(
    parameter int SLICE_W = 4,
    parameter int WGT_W   = 8,
    parameter int ACC_W   = 24
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    nrn_clr,
    input  logic                    win_clr,
    input  logic                    wgt_take,
    input  logic signed [WGT_W-1:0] wgt_in,
    input  logic                    max_mode,
    input  logic signed [ACC_W-1:0] psum,
    input  logic                    judge_en,
    output logic                    skip
);
    localparam logic signed [ACC_W-1:0] LO_MAX = ACC_W'((1 << SLICE_W) - 1);

    logic signed [ACC_W-1:0] pos_sum, neg_sum, wgt_ext;
    logic signed [ACC_W-1:0] opt_bnd, pess_bnd;
    logic signed [ACC_W-1:0] win_floor;
    logic                    win_has;
    logic                    wgt_pos;

    always_comb begin
        wgt_ext  = {{(ACC_W-WGT_W){wgt_in[WGT_W-1]}}, wgt_in};
        wgt_pos  = !wgt_in[WGT_W-1] && (wgt_in != '0);
        opt_bnd  = psum + pos_sum * LO_MAX;
        pess_bnd = psum + neg_sum * LO_MAX;
        if (max_mode) begin
            skip = win_has && (opt_bnd < win_floor);
        end else begin
            skip = opt_bnd[ACC_W-1] || (opt_bnd == '0);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_sum   <= '0;
            neg_sum   <= '0;
            win_has   <= 1'b0;
            win_floor <= '0;
        end else begin
            if (nrn_clr) begin
                pos_sum <= '0;
                neg_sum <= '0;
            end else if (wgt_take) begin
                if (wgt_pos) begin
                    pos_sum <= pos_sum + wgt_ext;
                end else begin
                    neg_sum <= neg_sum + wgt_ext;
                end
            end
            if (win_clr) begin
                win_has   <= 1'b0;
                win_floor <= '0;
            end else if (judge_en && max_mode && !skip &&
                         (!win_has || pess_bnd > win_floor)) begin
                win_has   <= 1'b1;
                win_floor <= pess_bnd;
            end
        end
    end
endmodule

// File: rtl/psn_neuron.sv
// Two-pass predictive neuron element: high-nibble prediction, conditional low-nibble completion.
module psn_neuron
    import psn_pkg::*;
#(
    parameter int N_PAIRS = 8,
    parameter int SLICE_W = 4,
    parameter int WGT_W   = 8,
    parameter int ACC_W   = 24
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      nrn_start,
    input  logic                      nrn_mode,
    input  logic                      nrn_win_first,
    output logic                      nrn_ready,
    input  logic                      pair_valid,
    input  logic [2*SLICE_W-1:0]      pair_act,
    input  logic signed [WGT_W-1:0]   pair_wgt,
    output logic                      pair_ready,
    output logic                      exec_pass,
    output logic                      done,
    output logic                      skipped,
    output logic signed [ACC_W-1:0]   result
);
    localparam int IDX_W = $clog2(SLICE_W);
    localparam int CNT_W = $clog2(N_PAIRS + 1);

    psn_state_e              state, state_nx;
    logic [IDX_W-1:0]        bit_cnt;
    logic [CNT_W-1:0]        pair_cnt;
    logic                    mode_q, skip_q;
    logic                    nrn_go, pair_go, bit_last, pair_last, in_mac;
    logic                    judge_skip;
    logic [SLICE_W-1:0]      slice_sel;
    logic signed [ACC_W-1:0] acc;

    assign nrn_go    = nrn_start && (state == ST_IDLE);
    assign pair_go   = pair_valid && pair_ready;
    assign bit_last  = (bit_cnt == IDX_W'(SLICE_W - 1));
    assign pair_last = (pair_cnt == CNT_W'(N_PAIRS - 1));
    assign in_mac    = (state == ST_PRED_MAC) || (state == ST_EXEC_MAC);
    assign slice_sel = (state == ST_PRED_LOAD) ? pair_act[2*SLICE_W-1:SLICE_W]
                                               : pair_act[SLICE_W-1:0];

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:      if (nrn_start)  state_nx = ST_PRED_LOAD;
            ST_PRED_LOAD: if (pair_valid) state_nx = ST_PRED_MAC;
            ST_PRED_MAC:  if (bit_last)   state_nx = pair_last ? ST_JUDGE : ST_PRED_LOAD;
            ST_JUDGE:     state_nx = judge_skip ? ST_FINISH : ST_EXEC_LOAD;
            ST_EXEC_LOAD: if (pair_valid) state_nx = ST_EXEC_MAC;
            ST_EXEC_MAC:  if (bit_last)   state_nx = pair_last ? ST_FINISH : ST_EXEC_LOAD;
            ST_FINISH:    state_nx = ST_IDLE;
            default:      state_nx = ST_IDLE;
        endcase
    end

    // counters and latched neuron attributes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt  <= '0;
            pair_cnt <= '0;
            mode_q   <= MODE_RELU;
            skip_q   <= 1'b0;
        end else begin
            if (nrn_go) begin
                bit_cnt  <= '0;
                pair_cnt <= '0;
                mode_q   <= nrn_mode;
                skip_q   <= 1'b0;
            end else if (in_mac) begin
                bit_cnt <= bit_last ? '0 : bit_cnt + 1'b1;
                if (bit_last) pair_cnt <= pair_last ? '0 : pair_cnt + 1'b1;
            end else if (state == ST_JUDGE) begin
                skip_q <= judge_skip;
            end
        end
    end

    // outputs
    always_comb begin
        nrn_ready  = (state == ST_IDLE);
        pair_ready = (state == ST_PRED_LOAD) || (state == ST_EXEC_LOAD);
        exec_pass  = (state == ST_EXEC_LOAD) || (state == ST_EXEC_MAC);
        done       = (state == ST_FINISH);
        skipped    = (state == ST_FINISH) && skip_q;
        result     = ((state == ST_FINISH) && !skip_q) ? acc : '0;
    end

    psn_serial_mac #(.SLICE_W(SLICE_W), .WGT_W(WGT_W), .ACC_W(ACC_W)) u_mac (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (nrn_go),
        .load     (pair_go),
        .slice_in (slice_sel),
        .wgt_in   (pair_wgt),
        .step     (in_mac),
        .hi_pass  (state == ST_PRED_MAC),
        .bit_idx  (bit_cnt),
        .acc      (acc)
    );

    psn_judge #(.SLICE_W(SLICE_W), .WGT_W(WGT_W), .ACC_W(ACC_W)) u_judge (
        .clk      (clk),
        .rst_n    (rst_n),
        .nrn_clr  (nrn_go),
        .win_clr  (nrn_go && nrn_win_first),
        .wgt_take (pair_go && (state == ST_PRED_LOAD)),
        .wgt_in   (pair_wgt),
        .max_mode (mode_q),
        .psum     (acc),
        .judge_en (state == ST_JUDGE),
        .skip     (judge_skip)
    );
endmodule

// File: rtl/psn_neuron_chk.sv
module psn_neuron_chk #(
    parameter int ACC_W = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic             nrn_start,
    input logic             nrn_ready,
    input logic             pair_valid,
    input logic             pair_ready,
    input logic             exec_pass,
    input logic             done,
    input logic             skipped,
    input logic [ACC_W-1:0] result
);
    AST_PAIR_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (pair_valid && pair_ready) |=> !pair_ready ##1 !pair_ready ##1 !pair_ready ##1 !pair_ready); // R8

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9

    AST_SKIP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (done && skipped) |-> (result == '0)); // R6

    AST_READY_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(nrn_ready && pair_ready)); // R9

    AST_START_LEAVES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (nrn_start && nrn_ready) |=> !nrn_ready); // R9

    AST_EXEC_NOT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        exec_pass |-> !done); // R7

    AST_SKIP_ONLY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        skipped |-> done); // R6
endmodule

bind psn_neuron psn_neuron_chk #(.ACC_W(ACC_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .nrn_start  (nrn_start),
    .nrn_ready  (nrn_ready),
    .pair_valid (pair_valid),
    .pair_ready (pair_ready),
    .exec_pass  (exec_pass),
    .done       (done),
    .skipped    (skipped),
    .result     (result)
);

// File: tb/psn_neuron_tb.sv
`timescale 1ns/1ps
module psn_neuron_tb;
    localparam int N = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              nrn_start = 1'b0, nrn_mode = 1'b0, nrn_win_first = 1'b0;
    logic              nrn_ready;
    logic              pair_valid = 1'b0;
    logic [7:0]        pair_act = '0;
    logic signed [7:0] pair_wgt = '0;
    logic              pair_ready, exec_pass, done, skipped;
    logic signed [23:0] result;

    int n_chk = 0, n_bad = 0, cyc = 0;
    bit finished = 0;
    int act_a [N];
    int wgt_a [N];
    bit m_has = 0;
    int m_floor = 0;
    int lcg = 32'h1357;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    psn_neuron u_dut (
        .clk(clk), .rst_n(rst_n), .nrn_start(nrn_start), .nrn_mode(nrn_mode),
        .nrn_win_first(nrn_win_first), .nrn_ready(nrn_ready), .pair_valid(pair_valid),
        .pair_act(pair_act), .pair_wgt(pair_wgt), .pair_ready(pair_ready),
        .exec_pass(exec_pass), .done(done), .skipped(skipped), .result(result)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // requirement model: returns skip decision and expected result, updates window floor
    function automatic void model(input bit mode, input bit wf, output bit sk, output int res);
        int psum = 0, pos = 0, neg = 0, exact = 0, opt, pess;
        for (int i = 0; i < N; i++) begin
            psum  += (act_a[i] >> 4) * 16 * wgt_a[i];
            exact += act_a[i] * wgt_a[i];
            if (wgt_a[i] > 0) pos += wgt_a[i];
            else              neg += wgt_a[i];
        end
        opt  = psum + 15 * pos;
        pess = psum + 15 * neg;
        if (wf) m_has = 0;
        if (!mode) begin
            sk = (opt <= 0);
        end else begin
            sk = m_has && (opt < m_floor);
            if (!sk && (!m_has || pess > m_floor)) begin
                m_floor = pess;
                m_has   = 1;
            end
        end
        res = sk ? 0 : exact;
    endfunction

    // entered at a negedge; returns at a negedge after the handshake edge
    task automatic send_pair(input int a, input int w);
        pair_valid = 1'b1;
        pair_act   = 8'(a);
        pair_wgt   = 8'(w);
        while (!pair_ready) @(negedge clk);
        @(negedge clk);
        pair_valid = 1'b0;
    endtask

    task automatic run_neuron(input string tag, input bit mode, input bit wf);
        bit sk_e, saw_exec;
        int res_e, t0, n_pairs;
        model(mode, wf, sk_e, res_e);
        @(negedge clk);
        while (!nrn_ready) @(negedge clk);
        nrn_start = 1'b1; nrn_mode = mode; nrn_win_first = wf;
        @(negedge clk);
        nrn_start = 1'b0; nrn_win_first = 1'b0;
        t0 = cyc;
        n_pairs = 0;
        saw_exec = 0;
        for (int i = 0; i < N; i++) begin send_pair(act_a[i], wgt_a[i]); n_pairs++; end
        while (!done && !exec_pass) @(negedge clk);
        if (exec_pass) begin
            saw_exec = 1;
            for (int i = 0; i < N; i++) begin send_pair(act_a[i], wgt_a[i]); n_pairs++; end
            while (!done) @(negedge clk);
        end
        check({tag, " skipped R4/R5"}, int'(skipped), int'(sk_e));
        check({tag, " result R3/R6"}, int'(result), res_e);
        check({tag, " pairs consumed R6/R7 R2"}, n_pairs, sk_e ? N : 2 * N);
        check({tag, " exec_pass seen R7"}, int'(saw_exec), int'(!sk_e));
        check({tag, " latency R8"}, cyc - t0, sk_e ? 5 * N + 1 : 10 * N + 1);
        @(negedge clk);
        check({tag, " done pulse R9"}, int'(done), 0);
    endtask

    task automatic clear_vec();
        for (int i = 0; i < N; i++) begin act_a[i] = 0; wgt_a[i] = 0; end
    endtask

    task automatic t_reset();
        check("reset nrn_ready R1", int'(nrn_ready), 1);
        check("reset pair_ready R1", int'(pair_ready), 0);
        check("reset exec_pass R1", int'(exec_pass), 0);
        check("reset done R1", int'(done), 0);
    endtask

    task automatic t_relu_keep();
        int acts [N] = '{8'h12, 8'h34, 8'hFF, 8'h80, 8'h01, 8'h7E, 8'h55, 8'hA9};
        for (int i = 0; i < N; i++) begin act_a[i] = acts[i]; wgt_a[i] = i + 1; end
        run_neuron("relu_keep R3", 1'b0, 1'b0);
    endtask

    task automatic t_relu_skip();
        for (int i = 0; i < N; i++) begin act_a[i] = 8'hF3; wgt_a[i] = -20 - i; end
        run_neuron("relu_skip R6", 1'b0, 1'b0);
    endtask

    task automatic t_relu_edge();
        // R2/R4: P = 16*1*(-15) = -240, bound 15*16 = 240 -> exactly 0 -> skip
        clear_vec();
        act_a[0] = 8'h1F; wgt_a[0] = -15;
        act_a[1] = 8'h0F; wgt_a[1] = 16;
        run_neuron("relu_zero_bound R4", 1'b0, 1'b0);
        // bound 255 -> +15 -> kept, exact -465+255 = -210
        wgt_a[1] = 17;
        run_neuron("relu_just_above R4", 1'b0, 1'b0);
    endtask

    task automatic t_maxpool();
        // R5: window floor 480 from first neuron
        clear_vec(); act_a[0] = 8'hF0; wgt_a[0] = 2;
        run_neuron("pool_first R5", 1'b1, 1'b1);
        clear_vec(); act_a[0] = 8'h0F; wgt_a[0] = 31;   // opt 465 < 480 -> skip
        run_neuron("pool_below R5", 1'b1, 1'b0);
        clear_vec(); act_a[0] = 8'h0F; wgt_a[0] = 32;   // opt 480 == floor -> kept
        run_neuron("pool_equal R5", 1'b1, 1'b0);
        clear_vec(); act_a[0] = 8'h0F; wgt_a[0] = 31;   // ReLU neuron leaves window alone
        run_neuron("relu_in_window R5", 1'b0, 1'b0);
        run_neuron("pool_below_again R5", 1'b1, 1'b0);
        run_neuron("pool_new_window R5", 1'b1, 1'b1);   // window cleared -> kept
    endtask

    task automatic t_mixed();
        for (int k = 0; k < 6; k++) begin
            for (int i = 0; i < N; i++) begin
                lcg = lcg * 1103515245 + 12345;
                act_a[i] = (lcg >>> 8) & 255;
                lcg = lcg * 1103515245 + 12345;
                wgt_a[i] = ((lcg >>> 8) & 255) - 128;
            end
            run_neuron("mixed R3", k[0], k == 0);
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_relu_keep();
        t_relu_skip();
        t_relu_edge();
        t_maxpool();
        t_mixed();
        finished = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog R8 actual=%0d expected=%0d", cyc, 0);
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule